// File: doc/BRIEF.md
# Third-Order Sinc Integrator Bank with Timed Capture

This block is the front half of a third-order sinc (CIC) decimator for the single-bit output of a sigma-delta modulator. It has three cascaded integrators, and each one updates on every clock. The first integrator adds the incoming bit, the second adds the first, and the third adds the second. The integrators are never cleared. They wrap freely, and the correct result depends on modular arithmetic. The differentiating (comb) stages run downstream, usually in software.

A programmable interval timer copies the last integrator into a capture register at a fixed period and raises a ready flag. A host read port returns that capture. On request, the port instead returns the low bits of the first or second integrator, which are all the downstream combs need at moderate periods. A mode input switches the block to second-order operation. In that mode the third stage holds still and the second integrator becomes the captured and reported value, at full width.

Because the integrators are not cleared, the first two differenced outputs after a restart, a period change or a channel change carry stale comb state and are discarded downstream.

Top module: `sinc3_integ_bank`

## Requirements
- R1: Each clock, stage 1 adds `mod_bit` (0 or 1), stage 2 adds the previous stage-1 value, and stage 3 adds the previous stage-2 value.
- R2: All stages wrap modulo 2^ACC_W with no saturation, and continued operation past a wrap stays correct.
- R3: Counting from reset or from the last accepted period write, a capture happens every P clocks. The capture takes the selected stage value as it stood before that clock edge and clears no stage.
- R4: The third-order difference (second-order in mode `order2`) of consecutive captures, taken modulo 2^ACC_W, equals the sum of the input bits weighted by the matching sinc kernel.
- R5: `rdy` sets on every capture and clears on a report read (`rd_sel`=0). A capture in the same cycle as the read wins.
- R6: `ovr` sets when a capture arrives while `rdy` is still set and no report read is taking place. A report read without a capture clears it.
- R7: A read returns data on the cycle after `rd_en`, with `rd_valid` high for exactly that cycle. `rd_sel`=1 returns the low LO1_W bits of stage 1, and `rd_sel`=2 or 3 returns the low LO2_W bits of stage 2. Both are zero-extended, and neither affects `rdy` or `ovr`.
- R8: An accepted period write restarts the interval count from zero. The next capture comes P_new clocks after the write, and the stages keep running through it.
- R9: A period write of 0, or one above MAX_P3 in third-order mode (above MAX_P2 in `order2`), is rejected. The old period and the count are kept, and `per_bad` is set. An accepted write clears `per_bad`.
- R10: With `order2` high, stage 3 holds, the capture takes stage 2, `rd_sel`=2 returns stage 2 at full width, and periods up to MAX_P2 are accepted.
- R11: After reset, all stages are 0, the period is RST_PERIOD, and `rdy`, `ovr`, `per_bad` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_bit | input | 1 | Modulator output bit |
| order2 | input | 1 | Second-order mode |
| per_wr | input | 1 | Period write strobe |
| per_data | input | PER_W | Period value in clocks |
| per_bad | output | 1 | Last period write was rejected |
| rd_en | input | 1 | Read request |
| rd_sel | input | 2 | 0 capture, 1 stage-1 low bits, 2/3 stage-2 |
| rd_data | output | ACC_W | Registered read data |
| rd_valid | output | 1 | rd_data updated this cycle |
| rdy | output | 1 | Unread capture present |
| ovr | output | 1 | A capture was lost before being read |

## Verification
The bench uses ACC_W=32, LO1_W=11, LO2_W=21 and MAX_P3=1625. It shortens RST_PERIOD to 64, so the first captures after reset arrive within a few hundred clocks. The bench also writes periods of 37, 1625 and (in second-order mode) 2000. At 1625 with a constant-one input, stage 3 wraps many times between captures while the third difference stays just inside 32 bits, which exercises the modular-arithmetic claim at its limit. The 2000-clock second-order run shows the wider period limit and a stage-2 value that outgrows its 21 low bits.

// File: rtl/sinc3_integ_pkg.sv
package sinc3_integ_pkg;

  typedef enum logic [1:0] {
    SEL_REPORT   = 2'd0,
    SEL_STAGE1   = 2'd1,
    SEL_STAGE2   = 2'd2,
    SEL_STAGE2_B = 2'd3
  } rd_sel_e;

  // Keep the n least significant bits of a value, zeroing the rest.
  function automatic logic [63:0] keep_low(input logic [63:0] v, input int unsigned n);
    if (n >= 64) return v;
    return v & ((64'd1 << n) - 64'd1);
  endfunction

  // A period is usable when non-zero and within the limit of the current mode.
  function automatic logic period_ok(input logic [31:0] per, input logic [31:0] lim);
    return (per != 32'd0) && (per <= lim);
  endfunction

  // Wrapping accumulate step shared by all stages.
  function automatic logic [63:0] wrap_add(input logic [63:0] a, input logic [63:0] b);
    return a + b;
  endfunction

endpackage

// File: rtl/sinc_integ_stage.sv
module sinc_integ_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] addend,
  output logic [W-1:0] acc_q
);
  import sinc3_integ_pkg::*;

  logic [63:0] sum_w;
  assign sum_w = wrap_add(64'(acc_q), 64'(addend));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= sum_w[W-1:0];
  end
endmodule

// File: rtl/sinc_period_timer.sv
module sinc_period_timer #(
  parameter int PER_W      = 16,
  parameter int RST_PERIOD = 1024,
  parameter int MAX_P3     = 1625,
  parameter int MAX_P2     = 65535
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             order2,
  input  logic             per_wr,
  input  logic [PER_W-1:0] per_data,
  output logic             tick,
  output logic             per_load,
  output logic             per_bad
);
  import sinc3_integ_pkg::*;

  logic [PER_W-1:0] period_q;
  logic [PER_W-1:0] cnt_q;
  logic [31:0]      lim_w;

  assign lim_w    = order2 ? 32'(MAX_P2) : 32'(MAX_P3);
  assign per_load = per_wr && period_ok(32'(per_data), lim_w);
  // An accepted write takes precedence over an expiring interval.
  assign tick     = !per_load && (cnt_q == (period_q - PER_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= PER_W'(RST_PERIOD);
      cnt_q    <= '0;
      per_bad  <= 1'b0;
    end else if (per_load) begin
      period_q <= per_data;
      cnt_q    <= '0;
      per_bad  <= 1'b0;
    end else begin
      if (per_wr) per_bad <= 1'b1;
      if (tick)   cnt_q   <= '0;
      else        cnt_q   <= cnt_q + PER_W'(1);
    end
  end
endmodule

// File: rtl/sinc_report_unit.sv
module sinc_report_unit #(
  parameter int W     = 32,
  parameter int LO1_W = 11,
  parameter int LO2_W = 21
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         order2,
  input  logic         tick,
  input  logic [W-1:0] stage1,
  input  logic [W-1:0] stage2,
  input  logic [W-1:0] stage3,
  input  logic         rd_en,
  input  logic [1:0]   rd_sel,
  output logic         rpt_read,
  output logic         rdy,
  output logic         ovr,
  output logic [W-1:0] rd_data,
  output logic         rd_valid
);
  import sinc3_integ_pkg::*;

  logic [W-1:0] snap_q;
  logic [W-1:0] mux_w;
  rd_sel_e      sel_w;

  assign sel_w    = rd_sel_e'(rd_sel);
  assign rpt_read = rd_en && (sel_w == SEL_REPORT);

  always_comb begin
    unique case (sel_w)
      SEL_REPORT: mux_w = snap_q;
      SEL_STAGE1: mux_w = W'(keep_low(64'(stage1), LO1_W));
      default:    mux_w = order2 ? stage2 : W'(keep_low(64'(stage2), LO2_W));
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q   <= '0;
      rdy      <= 1'b0;
      ovr      <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (tick) snap_q <= order2 ? stage2 : stage3;

      if (tick)          rdy <= 1'b1;
      else if (rpt_read) rdy <= 1'b0;

      if (tick && rdy && !rpt_read) ovr <= 1'b1;
      else if (rpt_read && !tick)   ovr <= 1'b0;

      if (rd_en) rd_data <= mux_w;
      rd_valid <= rd_en;
    end
  end
endmodule

// File: rtl/sinc3_integ_bank.sv
module sinc3_integ_bank #(
  parameter int ACC_W      = 32,
  parameter int PER_W      = 16,
  parameter int RST_PERIOD = 1024,
  parameter int MAX_P3     = 1625,
  parameter int MAX_P2     = 65535,
  parameter int LO1_W      = 11,
  parameter int LO2_W      = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_bit,
  input  logic             order2,
  input  logic             per_wr,
  input  logic [PER_W-1:0] per_data,
  output logic             per_bad,
  input  logic             rd_en,
  input  logic [1:0]       rd_sel,
  output logic [ACC_W-1:0] rd_data,
  output logic             rd_valid,
  output logic             rdy,
  output logic             ovr
);
  localparam int N_STAGES  = 3;
  localparam int LAST_STG  = N_STAGES - 1;

  logic [ACC_W-1:0] acc_q    [N_STAGES];
  logic [ACC_W-1:0] stage_in [N_STAGES];
  logic             stage_en [N_STAGES];

  // Named internal events, observed by the bound checker.
  logic             snap_evt;
  logic             per_load;
  logic             rpt_read;
  logic [ACC_W-1:0] acc1_w, acc2_w, acc3_w;

  for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
    if (s == 0) begin : g_head
      assign stage_in[s] = {{(ACC_W-1){1'b0}}, mod_bit};
    end else begin : g_chain
      assign stage_in[s] = acc_q[s-1];
    end
    if (s == LAST_STG) begin : g_tail_en
      assign stage_en[s] = !order2;
    end else begin : g_always_en
      assign stage_en[s] = 1'b1;
    end
    sinc_integ_stage #(.W(ACC_W)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (stage_en[s]),
      .addend (stage_in[s]),
      .acc_q  (acc_q[s])
    );
  end

  assign acc1_w = acc_q[0];
  assign acc2_w = acc_q[1];
  assign acc3_w = acc_q[2];

  sinc_period_timer #(
    .PER_W      (PER_W),
    .RST_PERIOD (RST_PERIOD),
    .MAX_P3     (MAX_P3),
    .MAX_P2     (MAX_P2)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .order2   (order2),
    .per_wr   (per_wr),
    .per_data (per_data),
    .tick     (snap_evt),
    .per_load (per_load),
    .per_bad  (per_bad)
  );

  sinc_report_unit #(
    .W     (ACC_W),
    .LO1_W (LO1_W),
    .LO2_W (LO2_W)
  ) u_report (
    .clk      (clk),
    .rst_n    (rst_n),
    .order2   (order2),
    .tick     (snap_evt),
    .stage1   (acc1_w),
    .stage2   (acc2_w),
    .stage3   (acc3_w),
    .rd_en    (rd_en),
    .rd_sel   (rd_sel),
    .rpt_read (rpt_read),
    .rdy      (rdy),
    .ovr      (ovr),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );
endmodule

// File: rtl/sinc3_integ_chk.sv
module sinc3_integ_chk #(
  parameter int W      = 32,
  parameter int PER_W  = 16,
  parameter int MAX_P3 = 1625,
  parameter int MAX_P2 = 65535
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mod_bit,
  input logic             order2,
  input logic             per_wr,
  input logic [PER_W-1:0] per_data,
  input logic             per_bad,
  input logic             rd_en,
  input logic [1:0]       rd_sel,
  input logic             rd_valid,
  input logic             rdy,
  input logic             ovr,
  input logic             snap_evt,
  input logic [W-1:0]     acc1,
  input logic [W-1:0]     acc2,
  input logic [W-1:0]     acc3
);
  logic        seen;
  logic        rpt_rd;
  logic        wr_bad;
  logic [31:0] lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  assign rpt_rd = rd_en && (rd_sel == 2'd0);
  assign lim    = order2 ? 32'(MAX_P2) : 32'(MAX_P3);
  assign wr_bad = per_wr && ((per_data == '0) || (32'(per_data) > lim));

  a_r1_stage1_step: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> acc1 == $past(acc1) + W'($past(mod_bit)));

  a_r2_stage3_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !$past(order2)) |-> acc3 == $past(acc3) + $past(acc2));

  a_r10_stage3_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(order2)) |-> acc3 == $past(acc3));

  a_r5_ready_sets: assert property (@(posedge clk) disable iff (!rst_n)
    snap_evt |=> rdy);

  a_r5_ready_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_rd && !snap_evt) |=> !rdy);

  a_r6_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_evt && rdy && !rpt_rd) |=> ovr);

  a_r6_overrun_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_rd && !snap_evt) |=> !ovr);

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  a_r9_reject_flags: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> per_bad);

  a_r8_restart_no_snap: assert property (@(posedge clk) disable iff (!rst_n)
    (per_wr && !wr_bad && per_data > PER_W'(1)) |=> !snap_evt);
endmodule

bind sinc3_integ_bank sinc3_integ_chk #(
  .W      (ACC_W),
  .PER_W  (PER_W),
  .MAX_P3 (MAX_P3),
  .MAX_P2 (MAX_P2)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mod_bit  (mod_bit),
  .order2   (order2),
  .per_wr   (per_wr),
  .per_data (per_data),
  .per_bad  (per_bad),
  .rd_en    (rd_en),
  .rd_sel   (rd_sel),
  .rd_valid (rd_valid),
  .rdy      (rdy),
  .ovr      (ovr),
  .snap_evt (snap_evt),
  .acc1     (acc1_w),
  .acc2     (acc2_w),
  .acc3     (acc3_w)
);

// File: tb/sinc3_integ_bank_bench.sv
module sinc3_integ_bank_bench;
  localparam int  ACC_W  = 32;
  localparam int  PER_W  = 16;
  localparam int  RST_P  = 64;
  localparam int  MAX_P3 = 1625;
  localparam int  MAX_P2 = 65535;
  localparam int  LO1    = 11;
  localparam int  LO2    = 21;
  localparam longint M32 = 64'hFFFF_FFFF;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mod_bit = 1'b0;
  logic             order2 = 1'b0;
  logic             per_wr = 1'b0;
  logic [PER_W-1:0] per_data = '0;
  logic             rd_en = 1'b0;
  logic [1:0]       rd_sel = 2'd0;
  logic             per_bad, rd_valid, rdy, ovr;
  logic [ACC_W-1:0] rd_data;

  always #4 clk = ~clk;

  sinc3_integ_bank #(
    .ACC_W(ACC_W), .PER_W(PER_W), .RST_PERIOD(RST_P), .MAX_P3(MAX_P3),
    .MAX_P2(MAX_P2), .LO1_W(LO1), .LO2_W(LO2)
  ) u_sinc3_integ_bank (
    .clk(clk), .rst_n(rst_n), .mod_bit(mod_bit), .order2(order2),
    .per_wr(per_wr), .per_data(per_data), .per_bad(per_bad),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .rd_valid(rd_valid),
    .rdy(rdy), .ovr(ovr)
  );

  typedef struct { int edge_i; int n; longint val; } item_t;

  int     n_cmp = 0, n_bad = 0;
  int     ecnt = 0;
  bit     bits[$];
  item_t  sbq[$];
  int     ord = 3, cur_p = RST_P, r_edge = 0, ticks = 0;
  bit     auto_rd = 0, pend = 0;
  item_t  pit;
  longint last_val = 0;
  longint hy[4];
  int     hn[4];
  int     hc = 0;
  int     lfsr = 32'h1ACE;

  always @(posedge clk) begin
    if (!rst_n) ecnt = 0;
    else        ecnt = ecnt + 1;
  end

  function automatic longint wt(input longint d, input int k);
    case (k)
      1:       return (d >= 0) ? 64'd1 : 64'd0;
      2:       return (d >= 1) ? d : 64'd0;
      default: return (d >= 2) ? (d * (d - 1)) / 2 : 64'd0;
    endcase
  endfunction

  function automatic longint direct(input int n, input int k);
    longint s = 0;
    for (int j = 1; j <= n; j++) if (bits[j]) s += wt(longint'(n - j), k);
    return s & M32;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit next_rand();
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'h8020_0003 : 32'h0);
    return lfsr[0];
  endfunction

  // R4: difference consecutive captures and compare with the kernel sum.
  task automatic comb_check(input int n, input longint y);
    int     c[4];
    longint act, exp, w;
    for (int i = 3; i > 0; i--) begin hy[i] = hy[i-1]; hn[i] = hn[i-1]; end
    hy[0] = y; hn[0] = n; hc++;
    if (ord == 3) begin c[0] = 1; c[1] = -3; c[2] = 3; c[3] = -1; end
    else          begin c[0] = 1; c[1] = -2; c[2] = 1; c[3] = 0; end
    if (hc >= ord + 1) begin
      act = 0; exp = 0;
      for (int i = 0; i <= ord; i++) act += c[i] * hy[i];
      for (int j = 1; j <= hn[0]; j++) if (bits[j]) begin
        w = 0;
        for (int i = 0; i <= ord; i++) w += c[i] * wt(longint'(hn[i] - j), ord);
        exp += w;
      end
      check((act & M32) == (exp & M32), "R4 comb difference", act & M32, exp & M32);
    end
  endtask

  // Scoreboard monitor, run once per cycle at the falling edge.
  task automatic monitor();
    item_t it;
    if (!auto_rd) hc = 0;
    if (pend) begin
      rd_en = 1'b0; pend = 0;
      check(rd_valid && longint'(rd_data) == pit.val, "R3 capture value", longint'(rd_data), pit.val);
      check(rdy == 1'b0, "R5 ready clears after report read", rdy, 0);
      comb_check(pit.n, longint'(rd_data));
    end
    while (sbq.size() > 0 && sbq[0].edge_i < ecnt) begin
      it = sbq.pop_front();
      check(0, "R3 capture missing", ecnt, it.edge_i);
    end
    if (sbq.size() > 0 && sbq[0].edge_i == ecnt) begin
      it = sbq.pop_front();
      check(rdy == 1'b1, "R5 ready on capture", rdy, 1);
      last_val = it.val;
      if (auto_rd) begin rd_en = 1'b1; rd_sel = 2'd0; pend = 1; pit = it; end
    end else if (auto_rd && !pend && rdy) begin
      check(0, "R3 capture at unexpected clock", ecnt, -1);
    end
  endtask

  // Driver: applies one clock of input and pushes expected captures.
  task automatic step(input bit b, input bit wr = 1'b0, input int wv = 0);
    int    e;
    bit    ok_wr;
    item_t it;
    per_wr = wr; per_data = PER_W'(wv); mod_bit = b;
    e = ecnt + 1;
    bits.push_back(b);
    ok_wr = wr && (wv != 0) && (wv <= (order2 ? MAX_P2 : MAX_P3));
    if (ok_wr) begin
      r_edge = e; cur_p = wv;
    end else if (((e - r_edge) % cur_p) == 0) begin
      it.edge_i = e; it.n = e - 1; it.val = direct(e - 1, ord);
      sbq.push_back(it); ticks++;
    end
    @(posedge clk); @(negedge clk);
    per_wr = 1'b0;
    monitor();
  endtask

  task automatic side_read(input logic [1:0] sel, input longint exp, input string tag);
    rd_en = 1'b1; rd_sel = sel;
    step(next_rand());
    rd_en = 1'b0;
    check(rd_valid && longint'(rd_data) == exp, tag, longint'(rd_data), exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rd_en = 1'b0; pend = 0; hc = 0; auto_rd = 0;
    sbq.delete(); bits.delete(); bits.push_back(1'b0);
    ticks = 0; r_edge = 0; cur_p = RST_P;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad + 1);
    $finish;
  end

  initial begin : main
    int t0;
    do_reset();
    // R11: reset state
    check(rdy == 0 && ovr == 0, "R11 reset flags", {rdy, ovr}, 0);
    check(per_bad == 0 && rd_valid == 0, "R11 reset per_bad/rd_valid", {per_bad, rd_valid}, 0);
    auto_rd = 1;
    // R3 R11: random bits, first capture due at RST_P
    for (int i = 0; i < RST_P * 4; i++) step(next_rand());
    // R1 R3: alternating and sparse patterns
    for (int i = 0; i < RST_P * 2; i++) step(i[0]);
    for (int i = 0; i < RST_P * 2; i++) step((i % 7) == 0);
    auto_rd = 0;
    step(1'b0);
    // R7: side reads return low bits one cycle later
    side_read(2'd1, direct(ecnt, 1) & ((64'd1 << LO1) - 1), "R7 stage1 low bits");
    side_read(2'd2, direct(ecnt, 2) & ((64'd1 << LO2) - 1), "R7 stage2 low bits");
    side_read(2'd3, direct(ecnt, 2) & ((64'd1 << LO2) - 1), "R7 stage2 alias select");
    // R6: two captures without a read
    t0 = ticks;
    while (ticks < t0 + 1) step(next_rand());
    check(rdy == 1 && ovr == 0, "R6 no overrun on first capture", {rdy, ovr}, 2);
    while (ticks < t0 + 2) step(next_rand());
    check(ovr == 1, "R6 overrun on second capture", ovr, 1);
    side_read(2'd1, direct(ecnt, 1) & ((64'd1 << LO1) - 1), "R7 stage1 read during overrun");
    check(rdy == 1 && ovr == 1, "R7 side read leaves flags", {rdy, ovr}, 3);
    side_read(2'd0, last_val, "R6 report holds latest capture");
    check(rdy == 0 && ovr == 0, "R6 report read clears flags", {rdy, ovr}, 0);
    // R8: period write restarts the interval
    auto_rd = 1;
    step(next_rand(), 1'b1, 37);
    for (int i = 0; i < 37 * 6; i++) step(next_rand());
    // R9: rejected writes keep schedule
    step(next_rand(), 1'b1, 2000);
    check(per_bad == 1, "R9 oversize period rejected", per_bad, 1);
    for (int i = 0; i < 50; i++) step(next_rand());
    step(next_rand(), 1'b1, 0);
    check(per_bad == 1, "R9 zero period rejected", per_bad, 1);
    for (int i = 0; i < 50; i++) step(next_rand());
    step(1'b1, 1'b1, MAX_P3);
    check(per_bad == 0, "R9 valid write clears flag", per_bad, 0);
    // R2: constant ones, stage 3 wraps many times
    for (int i = 0; i < MAX_P3 * 6; i++) step(1'b1);
    auto_rd = 0;
    step(1'b0); step(1'b0);
    // R10: second-order mode
    order2 = 1'b1; ord = 2;
    do_reset();
    auto_rd = 1;
    step(next_rand(), 1'b1, 2000);
    check(per_bad == 0, "R10 long period accepted in order2", per_bad, 0);
    for (int i = 0; i < 2000 * 5; i++) step(next_rand());
    auto_rd = 0;
    step(1'b0);
    side_read(2'd2, direct(ecnt, 2), "R10 stage2 full width");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule